// File: doc/BRIEF.md
# Code-Division Spreading Bus Transmitter

This block carries several slow single-bit peripheral signals over one narrow parallel bus. It does not give the channels turns on the bus. Each channel spreads its current data bit across a full spreading code: the channel sends the code itself when the bit is 0 and the complement of the code when the bit is 1. In every chip period the block adds the chips of all enabled channels at the same code position. It drives that sum as a binary word on the bus, so a matching receiver can separate the channels again by correlation.

Software loads one code word per channel while the block is idle. Each frame lasts one code length of chip clocks. At the start of a frame the block samples the data bits and the channel enables, and copies the loaded codes into the working copy. It raises a frame strobe during the first chip so that receivers can align. While the run request is held, frames follow one another with no gap. When the request is dropped, the current frame completes first and the block then returns to idle. For an orthogonal set the codes should be balanced and pairwise orthogonal, for example the non-constant rows of a Walsh matrix. The highest bit rate per channel is the chip clock divided by the code length.

Top module: `cdma_spread_tx`

## Requirements
- R1: After reset, sum_o is 0, frame_o is 0 and busy_o is 0, and all code words are 0.
- R2: When run_i is high while the block is idle, a frame starts at the next clock edge. That edge samples data_i and ch_en_i. busy_o is high for the whole frame, and sum_o carries chip 0 in the cycle after that edge.
- R3: A frame lasts CODE_LEN (8) chip periods. frame_o is high only during chip 0 of each frame. If run_i is high during the last chip, the next frame starts with no idle cycle in between.
- R4: In chip k (k = 0..7), the chip of channel c equals data bit c XOR bit k of that channel's code word. Bit 0 of the code word is sent first.
- R5: sum_o is the number of enabled channels whose chip is 1, as an unsigned binary value SUM_W = 4 bits wide. It reaches 8 when all channels are enabled and all their chips are 1, with no overflow.
- R6: A channel whose enable bit was 0 when the frame started adds 0 to every chip of that frame.
- R7: A change on data_i or ch_en_i after the frame-start edge has no effect on the current frame. The new values are used only from the next frame start.
- R8: A write on code_we_i stores code_data_i for the channel given by code_sel_i (channel number in binary) only while busy_o is low. While busy_o is high the write is ignored.
- R9: A stored code word takes effect at the next frame start and stays in use unchanged for the whole frame.
- R10: When run_i is low during the last chip, the frame finishes and the block returns to idle in the next cycle, with busy_o low and sum_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Chip clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Request to send frames |
| code_we_i | input | 1 | Code word write strobe |
| code_sel_i | input | 3 | Channel selected for the code write |
| code_data_i | input | 8 | Code word, bit k = chip k |
| ch_en_i | input | 8 | Per-channel enable, sampled at frame start |
| data_i | input | 8 | Per-channel data bit, sampled at frame start |
| sum_o | output | 4 | Chip sum driven on the bus |
| frame_o | output | 1 | High during chip 0 of each frame |
| busy_o | output | 1 | High while a frame is in progress |

## Verification
The bench targets four behaviours:
- Back-to-back frames. A design that skips or repeats a chip at the frame boundary shifts every later sum by one chip, and the frame strobe drifts.
- A frame where every enabled chip is 1. A sum that is too narrow wraps to 0 there instead of giving 8.
- Changes to data and enables right after the frame start. A design that reads the inputs live instead of the sampled copies corrupts the rest of that frame.
- A code write attempted mid-frame, then a write made while idle. A design without the busy gate changes the code of a later frame. A design that applies the working copy late gives the wrong sums for the first frame after the write.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  localparam int unsigned NUM_CH_DEF   = 8;
  localparam int unsigned CODE_LEN_DEF = 8;

  function automatic int unsigned sum_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/cdma_chip_seq.sv
module cdma_chip_seq #(
  parameter int unsigned CODE_LEN = 8,
  localparam int unsigned IDX_W = (CODE_LEN > 1) ? $clog2(CODE_LEN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] chip_idx_o,
  output logic             frame_start_o,
  output logic             frame_o
);
  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic             last_chip;

  assign last_chip     = (idx_q == IDX_W'(CODE_LEN - 1));
  assign frame_start_o = run_i && (!busy_q || last_chip);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (frame_start_o) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (last_chip) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o     = busy_q;
  assign chip_idx_o = idx_q;
  assign frame_o    = busy_q && (idx_q == '0);

  a_r2_start_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && run_i) |=> (busy_q && idx_q == '0));
  a_r3_chip_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_chip) |=> (busy_q && idx_q == $past(idx_q) + 1'b1));
  a_r3_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && last_chip && run_i) |=> (busy_q && idx_q == '0));
  a_r10_stop_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && last_chip && !run_i) |=> !busy_q);
endmodule

// File: rtl/cdma_code_bank.sv
module cdma_code_bank #(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned CODE_LEN = 8,
  localparam int unsigned SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [SEL_W-1:0]                  sel_i,
  input  logic [CODE_LEN-1:0]               data_i,
  input  logic                              busy_i,
  input  logic                              load_i,
  output logic [NUM_CH-1:0][CODE_LEN-1:0]   code_o
);
  logic [NUM_CH-1:0][CODE_LEN-1:0] pend_q;
  logic [NUM_CH-1:0][CODE_LEN-1:0] act_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic wr_hit;
    assign wr_hit = we_i && !busy_i && (sel_i == SEL_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[g] <= '0;
        act_q[g]  <= '0;
      end else begin
        if (wr_hit) pend_q[g] <= data_i;
        if (load_i) act_q[g]  <= pend_q[g];
      end
    end
  end

  assign code_o = act_q;

  a_r8_no_write_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(pend_q));
  a_r9_code_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_q));
endmodule

// File: rtl/cdma_spreader.sv
module cdma_spreader #(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned CODE_LEN = 8,
  parameter int unsigned SUM_W    = 4,
  localparam int unsigned IDX_W = (CODE_LEN > 1) ? $clog2(CODE_LEN) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            load_i,
  input  logic                            active_i,
  input  logic [IDX_W-1:0]                chip_idx_i,
  input  logic [NUM_CH-1:0]               data_i,
  input  logic [NUM_CH-1:0]               en_i,
  input  logic [NUM_CH-1:0][CODE_LEN-1:0] code_i,
  output logic [SUM_W-1:0]                sum_o
);
  logic [NUM_CH-1:0] data_q;
  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] chip;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      en_q   <= '0;
    end else if (load_i) begin
      data_q <= data_i;
      en_q   <= en_i;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chip
    assign chip[g] = en_q[g] & (data_q[g] ^ code_i[g][chip_idx_i]);
  end

  always_comb begin
    sum_o = '0;
    if (active_i) begin
      for (int c = 0; c < NUM_CH; c++) sum_o = sum_o + SUM_W'(chip[c]);
    end
  end

  a_r7_inputs_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(data_q) && $stable(en_q)));
  a_r6_sum_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (int'(sum_o) <= $countones(en_q)));
  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> (sum_o == '0));
endmodule

// File: rtl/cdma_spread_tx.sv
module cdma_spread_tx
  import cdma_pkg::*;
#(
  parameter int unsigned NUM_CH   = NUM_CH_DEF,
  parameter int unsigned CODE_LEN = CODE_LEN_DEF,
  localparam int unsigned SUM_W = sum_width(NUM_CH),
  localparam int unsigned SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned IDX_W = (CODE_LEN > 1) ? $clog2(CODE_LEN) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                code_we_i,
  input  logic [SEL_W-1:0]    code_sel_i,
  input  logic [CODE_LEN-1:0] code_data_i,
  input  logic [NUM_CH-1:0]   ch_en_i,
  input  logic [NUM_CH-1:0]   data_i,
  output logic [SUM_W-1:0]    sum_o,
  output logic                frame_o,
  output logic                busy_o
);
  logic                            busy;
  logic                            frame_start;
  logic [IDX_W-1:0]                chip_idx;
  logic [NUM_CH-1:0][CODE_LEN-1:0] codes;

  cdma_chip_seq #(.CODE_LEN(CODE_LEN)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_i),
    .busy_o       (busy),
    .chip_idx_o   (chip_idx),
    .frame_start_o(frame_start),
    .frame_o      (frame_o)
  );

  cdma_code_bank #(.NUM_CH(NUM_CH), .CODE_LEN(CODE_LEN)) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (code_we_i),
    .sel_i (code_sel_i),
    .data_i(code_data_i),
    .busy_i(busy),
    .load_i(frame_start),
    .code_o(codes)
  );

  cdma_spreader #(.NUM_CH(NUM_CH), .CODE_LEN(CODE_LEN), .SUM_W(SUM_W)) u_spread (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (frame_start),
    .active_i  (busy),
    .chip_idx_i(chip_idx),
    .data_i    (data_i),
    .en_i      (ch_en_i),
    .code_i    (codes),
    .sum_o     (sum_o)
  );

  assign busy_o = busy;

  a_r3_frame_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> busy_o);
  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(sum_o) <= NUM_CH);
endmodule

// File: tb/cdma_spread_tx_tb_top.sv
module cdma_spread_tx_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       run_i = 1'b0;
  logic       code_we_i = 1'b0;
  logic [2:0] code_sel_i = '0;
  logic [7:0] code_data_i = '0;
  logic [7:0] ch_en_i = '0;
  logic [7:0] data_i = '0;
  logic [3:0] sum_o;
  logic       frame_o;
  logic       busy_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] model_code [8];

  // {data, enable}
  localparam logic [15:0] VECS [6] = '{
    {8'hFF, 8'hFF}, {8'h00, 8'hFF}, {8'hA5, 8'hFF},
    {8'h3C, 8'h0F}, {8'hFF, 8'h00}, {8'h5A, 8'h81}
  };

  always #10 clk_i = ~clk_i;

  cdma_spread_tx dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i),
    .code_we_i(code_we_i), .code_sel_i(code_sel_i), .code_data_i(code_data_i),
    .ch_en_i(ch_en_i), .data_i(data_i),
    .sum_o(sum_o), .frame_o(frame_o), .busy_o(busy_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] walsh_row(input int r);
    logic [7:0] w;
    for (int k = 0; k < 8; k++) w[k] = ^(3'(r) & 3'(k));
    return w;
  endfunction

  function automatic logic [7:0] exp_sum(input logic [7:0] d, input logic [7:0] e, input int k);
    int s = 0;
    for (int c = 0; c < 8; c++) if (e[c] && (d[c] ^ model_code[c][k])) s++;
    return 8'(s);
  endfunction

  task automatic write_code(input int ch, input logic [7:0] val, input bit accepted);
    code_we_i = 1'b1; code_sel_i = 3'(ch); code_data_i = val;
    @(posedge clk_i); @(negedge clk_i);
    code_we_i = 1'b0;
    if (accepted) model_code[ch] = val;
  endtask

  // entered at a negedge just before the frame-start edge
  task automatic run_frame(input logic [7:0] d, input logic [7:0] e,
                           input bit last, input bit mid_write);
    data_i = d; ch_en_i = e; run_i = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk_i); @(negedge clk_i);
      chk("R4/R5 sum", {4'b0, sum_o}, exp_sum(d, e, k));
      chk("R3 frame_o", {7'b0, frame_o}, {7'b0, k == 0});
      chk("R2 busy_o", {7'b0, busy_o}, 8'd1);
      if (k == 0) begin
        data_i = ~d; ch_en_i = ~e;   // R7: changes after sampling
      end
      if (k == 2 && mid_write) begin
        code_we_i = 1'b1; code_sel_i = 3'd0; code_data_i = ~model_code[0];
      end
      if (k == 3) code_we_i = 1'b0;  // R8: write while busy is ignored
      if (k == 7 && last) run_i = 1'b0;
    end
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 8; c++) model_code[c] = '0;
    repeat (2) @(negedge clk_i);
    chk("R1 sum_o reset", {4'b0, sum_o}, 8'd0);
    chk("R1 frame_o reset", {7'b0, frame_o}, 8'd0);
    chk("R1 busy_o reset", {7'b0, busy_o}, 8'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: codes are zero after reset, so chip k = data bit
    run_frame(8'h5A, 8'hFF, 1'b1, 1'b0);
    @(posedge clk_i); @(negedge clk_i);
    chk("R10 busy_o idle", {7'b0, busy_o}, 8'd0);

    for (int c = 0; c < 7; c++) write_code(c, walsh_row(c + 1), 1'b1);
    write_code(7, 8'h5A, 1'b1);

    // back-to-back frames from the vector table (R2 R3 R4 R5 R6 R7 R9)
    foreach (VECS[i]) run_frame(VECS[i][15:8], VECS[i][7:0], i == 5, 1'b0);
    @(posedge clk_i); @(negedge clk_i);
    chk("R10 busy_o after stop", {7'b0, busy_o}, 8'd0);
    chk("R10 sum_o after stop", {4'b0, sum_o}, 8'd0);
    chk("R10 frame_o after stop", {7'b0, frame_o}, 8'd0);
    @(negedge clk_i);
    chk("R10 stays idle", {7'b0, busy_o}, 8'd0);

    // R8: mid-frame write ignored, next frame uses old code
    run_frame(8'h01, 8'h01, 1'b1, 1'b1);
    @(negedge clk_i);
    run_frame(8'h00, 8'h01, 1'b1, 1'b0);
    @(negedge clk_i);

    // R9: idle write applies at next frame start
    write_code(0, 8'b0011_0110, 1'b1);
    run_frame(8'h00, 8'h01, 1'b1, 1'b0);
    @(negedge clk_i);
    // R5: all channels enabled, all chips one at chip 0
    run_frame(8'hFF, 8'hFF, 1'b1, 1'b0);
    chk("R5 full sum max", exp_sum(8'hFF, 8'hFF, 0), 8'd8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule